// File: doc/BRIEF.md
# Per-Queue Packet Counter and Ready Flag

This block adds packet awareness to a multi-queue FIFO. The word stream on the write side and the word stream on the read side each carry two marker bits above a 32-bit payload: one marks the first word of a packet and one marks the last. For every queue the block counts how many complete packets are stored. From these counts it produces a packet-ready bit for each queue and a packet-ready flag for the queue currently selected on the read side. The FIFO storage and any width conversion are outside this block. It only watches the strobes, queue numbers and marker bits that pass through the FIFO ports.

While packet tracking is active, the per-queue ready vector takes the place of the FIFO's almost-empty status vector. The ready flag takes the place of its almost-empty flag. Tracking is only allowed when both the input bus and the output bus run at full width. Otherwise the almost-empty values pass through unchanged. The block also checks the framing of every written packet and latches a sticky error bit for each queue. A partial reset of one queue clears that queue's count, error bit and framing state.

Top module: `pkt_ready_tracker`

## Requirements
- R1: `mode_active` is 1 exactly when `mode_req` is 1 and both `wr_bus_w` and `rd_bus_w` equal 0. The width codes are 0 for 36 bits, 1 for 18 bits and 2 for 9 bits.
- R2: While `mode_active` is 0, `status_vec` equals `ae_vec_in` and `status_flag` equals `ae_flag_in`. While it is 1, they carry packet-ready status.
- R3: A write with `wr_en`=1 and end marker `wr_word[33]`=1 increments the packet count of queue `wr_q`. The queue's `status_vec` bit reads 1 from the cycle after the write edge whenever its count is non-zero.
- R4: A read with `rd_en`=1 and end marker `rd_word[33]`=1 decrements the packet count of queue `rd_q`. The ready bit drops once the count reaches zero.
- R5: A count saturates at 2**CNT_W-1 (7 by default). A decrement when the count is zero leaves it at zero.
- R6: An increment and a decrement of the same queue in the same cycle leave its count unchanged.
- R7: In packet mode, `status_flag` is the ready bit of the queue on `rd_sel_q`.
- R8: An end marker that closes a packet of fewer than 4 words sets that queue's `err_vec` bit. The start marker is `wr_word[32]`. A word carrying both markers counts as a 1-word packet.
- R9: A start marker while a packet is still open on that queue sets its error bit. So does an end marker with no packet open.
- R10: Error bits are sticky, and a write with an end marker increments the count even when the packet was malformed.
- R11: `flush_en` clears the count, the error bit and the open-packet state of queue `flush_q` only, in any mode. It wins over a same-cycle write or read to that queue.
- R12: While `mode_active` is 0, writes and reads change no count and no error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req | input | 1 | Packet tracking requested |
| wr_bus_w | input | 2 | Input bus width code (0=36, 1=18, 2=9) |
| rd_bus_w | input | 2 | Output bus width code (0=36, 1=18, 2=9) |
| wr_en | input | 1 | Write strobe |
| wr_q | input | 3 | Queue being written |
| wr_word | input | 36 | Written word (bit 32 start, bit 33 end marker) |
| rd_en | input | 1 | Read strobe |
| rd_q | input | 3 | Queue being read |
| rd_word | input | 36 | Word read out (bit 32 start, bit 33 end marker) |
| flush_en | input | 1 | Partial reset of one queue |
| flush_q | input | 3 | Queue to partially reset |
| rd_sel_q | input | 3 | Queue selected on the read side for the flag |
| ae_vec_in | input | 8 | Almost-empty status vector from the FIFO |
| ae_flag_in | input | 1 | Almost-empty flag from the FIFO |
| mode_active | output | 1 | Packet tracking active |
| status_vec | output | 8 | Packet-ready vector or almost-empty vector |
| status_flag | output | 1 | Packet-ready flag or almost-empty flag |
| err_vec | output | 8 | Sticky per-queue framing error |

## Verification
A wrong count shows up at the ports only when that queue's count reaches or leaves zero. A saturation fault therefore stays hidden until the queue is drained, and it appears as a ready bit that drops several end-of-packet reads too early or too late. A framing state that is stale or never cleared shows up one cycle after the next marker word to that queue, as an error bit that is set wrongly or missing. That is why the stimulus drains queues fully, over-fills one queue past its limit, and puts partial resets next to open packets.

// File: rtl/pkt_trk_pkg.sv
package pkt_trk_pkg;
    // Width codes of the FIFO's input and output buses.
    typedef enum logic [1:0] {
        BUS_W36 = 2'd0,
        BUS_W18 = 2'd1,
        BUS_W9  = 2'd2
    } bus_width_e;

    // Marker bits extracted from one word.
    typedef struct packed {
        logic sop;
        logic eop;
    } marks_t;
endpackage

// File: rtl/pkt_mode_gate.sv
// Decides whether packet tracking is active.
// Assumes the width codes follow pkt_trk_pkg::bus_width_e.
module pkt_mode_gate
    import pkt_trk_pkg::*;
(
    input  logic       mode_req,
    input  logic [1:0] wr_bus_w,
    input  logic [1:0] rd_bus_w,
    output logic       active
);
    // Tracking is only legal when both ports run at full width.
    always_comb begin
        active = mode_req &&
                 (wr_bus_w == BUS_W36) &&
                 (rd_bus_w == BUS_W36);
    end
endmodule

// File: rtl/pkt_frame_check.sv
// Checks the write-side framing of one queue and latches a sticky error.
// It tracks whether a packet is open and how many words it has so far,
// saturating at MIN_WORDS-1.
// Assumes MIN_WORDS >= 2. clear has priority over everything except reset.
module pkt_frame_check #(
    parameter int MIN_WORDS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic wr_hit,
    input  logic sop,
    input  logic eop,
    output logic err
);
    localparam int LEN_W = (MIN_WORDS > 2) ? $clog2(MIN_WORDS) : 1;
    localparam logic [LEN_W-1:0] LEN_TOP = LEN_W'(MIN_WORDS - 1);

    logic             open_q;
    logic [LEN_W-1:0] len_q;

    // Open-packet state, word count and the sticky error bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            open_q <= 1'b0;
            len_q  <= '0;
            err    <= 1'b0;
        end else if (enable && wr_hit) begin
            if (sop) begin
                if (open_q || eop) err <= 1'b1;
                open_q <= !eop;
                len_q  <= eop ? '0 : LEN_W'(1);
            end else if (eop) begin
                if (!open_q || (len_q < LEN_TOP)) err <= 1'b1;
                open_q <= 1'b0;
                len_q  <= '0;
            end else if (open_q && (len_q != LEN_TOP)) begin
                len_q <= len_q + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/pkt_count_cell.sv
// Stored-packet counter for one queue. It saturates at its maximum and
// stops at zero. A same-cycle increment and decrement cancel out.
// Assumes clear (partial reset) wins over inc/dec.
module pkt_count_cell #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic inc,
    input  logic dec,
    output logic nonzero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Counter update with saturation at the top and a floor at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (enable) begin
            if (inc && !dec && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + CNT_W'(1);
            else if (dec && !inc && (cnt_q != '0)) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // A queue is ready when at least one whole packet is stored.
    always_comb nonzero = (cnt_q != '0);
endmodule

// File: rtl/pkt_status_sel.sv
// Chooses between packet-ready status and the FIFO's almost-empty status.
// Assumes sel is below NUM_Q.
module pkt_status_sel #(
    parameter int NUM_Q   = 8,
    parameter int Q_SEL_W = 3
) (
    input  logic               active,
    input  logic [NUM_Q-1:0]   ready_vec,
    input  logic [Q_SEL_W-1:0] sel,
    input  logic [NUM_Q-1:0]   ae_vec,
    input  logic               ae_flag,
    output logic [NUM_Q-1:0]   out_vec,
    output logic               out_flag
);
    // Packet mode takes over both the status vector and the single flag.
    always_comb begin
        out_vec  = active ? ready_vec : ae_vec;
        out_flag = active ? ready_vec[sel] : ae_flag;
    end
endmodule

// File: rtl/pkt_ready_tracker.sv
// Top of the packet tracker. It decodes per-queue hits from the write,
// read and partial-reset strobes, and keeps one counter and one framing
// checker per queue. It then drives the ready status onto the reused
// almost-empty outputs.
// Assumes queue numbers are below NUM_Q and that the read side supplies
// the marker bits of every word it pops.
module pkt_ready_tracker
    import pkt_trk_pkg::*;
#(
    parameter int NUM_Q     = 8,
    parameter int Q_SEL_W   = $clog2(NUM_Q),
    parameter int WORD_W    = 36,
    parameter int SOP_POS   = 32,
    parameter int EOP_POS   = 33,
    parameter int CNT_W     = 3,
    parameter int MIN_WORDS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_req,
    input  logic [1:0]         wr_bus_w,
    input  logic [1:0]         rd_bus_w,
    input  logic               wr_en,
    input  logic [Q_SEL_W-1:0] wr_q,
    input  logic [WORD_W-1:0]  wr_word,
    input  logic               rd_en,
    input  logic [Q_SEL_W-1:0] rd_q,
    input  logic [WORD_W-1:0]  rd_word,
    input  logic               flush_en,
    input  logic [Q_SEL_W-1:0] flush_q,
    input  logic [Q_SEL_W-1:0] rd_sel_q,
    input  logic [NUM_Q-1:0]   ae_vec_in,
    input  logic               ae_flag_in,
    output logic               mode_active,
    output logic [NUM_Q-1:0]   status_vec,
    output logic               status_flag,
    output logic [NUM_Q-1:0]   err_vec
);
    marks_t           wr_mk;
    marks_t           rd_mk;
    logic [NUM_Q-1:0] ready_vec;

    // Pull the marker bits out of both word streams.
    always_comb begin
        wr_mk.sop = wr_word[SOP_POS];
        wr_mk.eop = wr_word[EOP_POS];
        rd_mk.sop = rd_word[SOP_POS];
        rd_mk.eop = rd_word[EOP_POS];
    end

    pkt_mode_gate u_gate (
        .mode_req (mode_req),
        .wr_bus_w (wr_bus_w),
        .rd_bus_w (rd_bus_w),
        .active   (mode_active)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        logic wr_hit;
        logic rd_hit;
        logic clr;

        // Per-queue address decode of the strobes.
        always_comb begin
            wr_hit = wr_en && (wr_q == Q_SEL_W'(q));
            rd_hit = rd_en && (rd_q == Q_SEL_W'(q));
            clr    = flush_en && (flush_q == Q_SEL_W'(q));
        end

        pkt_count_cell #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clr),
            .enable  (mode_active),
            .inc     (wr_hit && wr_mk.eop),
            .dec     (rd_hit && rd_mk.eop),
            .nonzero (ready_vec[q])
        );

        pkt_frame_check #(.MIN_WORDS(MIN_WORDS)) u_frm (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clr),
            .enable (mode_active),
            .wr_hit (wr_hit),
            .sop    (wr_mk.sop),
            .eop    (wr_mk.eop),
            .err    (err_vec[q])
        );
    end

    pkt_status_sel #(.NUM_Q(NUM_Q), .Q_SEL_W(Q_SEL_W)) u_sel (
        .active    (mode_active),
        .ready_vec (ready_vec),
        .sel       (rd_sel_q),
        .ae_vec    (ae_vec_in),
        .ae_flag   (ae_flag_in),
        .out_vec   (status_vec),
        .out_flag  (status_flag)
    );
endmodule

// File: rtl/pkt_ready_tracker_chk.sv
// Property checker for pkt_ready_tracker, attached with bind below.
module pkt_ready_tracker_chk #(
    parameter int NUM_Q   = 8,
    parameter int Q_SEL_W = 3,
    parameter int WORD_W  = 36,
    parameter int EOP_POS = 33
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [WORD_W-1:0]  wr_word,
    input logic               rd_en,
    input logic [WORD_W-1:0]  rd_word,
    input logic               flush_en,
    input logic [Q_SEL_W-1:0] flush_q,
    input logic               mode_active,
    input logic [NUM_Q-1:0]   status_vec,
    input logic [NUM_Q-1:0]   err_vec
);
    // R3: a ready bit rises in packet mode only after a write with an end marker.
    a_r3_rise_needs_eop_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_active && $past(mode_active) && ((status_vec & ~$past(status_vec)) != '0))
        |-> $past(wr_en && wr_word[EOP_POS]));

    // R4: a ready bit falls in packet mode only after an end-marker read or a partial reset.
    a_r4_fall_needs_eop_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_active && $past(mode_active) && ((~status_vec & $past(status_vec)) != '0))
        |-> $past((rd_en && rd_word[EOP_POS]) || flush_en));

    // R11: a partial reset leaves the queue with no error and no stored packet.
    a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (!err_vec[$past(flush_q)] &&
                      (!mode_active || !status_vec[$past(flush_q)])));

    // R8: an error bit can only rise after a write in packet mode.
    a_r8_err_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_vec & ~$past(err_vec)) != '0) |-> $past(wr_en && mode_active));

    // R12: while tracking is off and no partial reset happens, errors hold.
    a_r12_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_active && !flush_en) |=> $stable(err_vec));
endmodule

bind pkt_ready_tracker pkt_ready_tracker_chk #(
    .NUM_Q   (NUM_Q),
    .Q_SEL_W (Q_SEL_W),
    .WORD_W  (WORD_W),
    .EOP_POS (EOP_POS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_word     (wr_word),
    .rd_en       (rd_en),
    .rd_word     (rd_word),
    .flush_en    (flush_en),
    .flush_q     (flush_q),
    .mode_active (mode_active),
    .status_vec  (status_vec),
    .err_vec     (err_vec)
);

// File: tb/pkt_ready_tracker_tb_top.sv
module pkt_ready_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NQ   = 8;
    localparam int QW   = 3;
    localparam int CMAX = 7;
    localparam int SOPB = 32;
    localparam int EOPB = 33;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_req = 1'b1;
    logic [1:0]    wr_bus_w = 2'd0, rd_bus_w = 2'd0;
    logic          wr_en = 1'b0, rd_en = 1'b0, flush_en = 1'b0;
    logic [QW-1:0] wr_q = '0, rd_q = '0, flush_q = '0, rd_sel_q = '0;
    logic [35:0]   wr_word = '0, rd_word = '0;
    logic [NQ-1:0] ae_vec_in = 8'hA5;
    logic          ae_flag_in = 1'b1;
    logic          mode_active, status_flag;
    logic [NQ-1:0] status_vec, err_vec;

    int  checks = 0, fails = 0;
    int  cnt_m [NQ];
    int  len_m [NQ];
    bit  err_m [NQ];
    bit  open_m[NQ];
    bit  done = 0;

    pkt_ready_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .wr_bus_w(wr_bus_w),
        .rd_bus_w(rd_bus_w), .wr_en(wr_en), .wr_q(wr_q), .wr_word(wr_word),
        .rd_en(rd_en), .rd_q(rd_q), .rd_word(rd_word), .flush_en(flush_en),
        .flush_q(flush_q), .rd_sel_q(rd_sel_q), .ae_vec_in(ae_vec_in),
        .ae_flag_in(ae_flag_in), .mode_active(mode_active),
        .status_vec(status_vec), .status_flag(status_flag), .err_vec(err_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit mode_f();
        return mode_req && (wr_bus_w == 2'd0) && (rd_bus_w == 2'd0);
    endfunction

    function automatic logic [NQ-1:0] exp_vec();
        logic [NQ-1:0] v;
        for (int q = 0; q < NQ; q++) v[q] = (cnt_m[q] != 0);
        return mode_f() ? v : ae_vec_in;
    endfunction

    function automatic logic [NQ-1:0] exp_err();
        logic [NQ-1:0] v;
        for (int q = 0; q < NQ; q++) v[q] = err_m[q];
        return v;
    endfunction

    task automatic model_reset();
        for (int q = 0; q < NQ; q++) begin
            cnt_m[q] = 0; len_m[q] = 0; err_m[q] = 0; open_m[q] = 0;
        end
    endtask

    // Reference update for one clock edge, from the requirements.
    task automatic model_edge();
        bit m;
        bit sop, eop;
        m = mode_f();
        sop = wr_word[SOPB];
        eop = wr_word[EOPB];
        for (int q = 0; q < NQ; q++) begin
            if (flush_en && flush_q == q) begin
                cnt_m[q] = 0; len_m[q] = 0; err_m[q] = 0; open_m[q] = 0;
            end else if (m) begin
                int n;
                bit inc, dec;
                inc = wr_en && wr_q == q && eop;
                dec = rd_en && rd_q == q && rd_word[EOPB];
                n = cnt_m[q] + int'(inc) - int'(dec);
                if (n > CMAX) n = CMAX;
                if (n < 0) n = 0;
                cnt_m[q] = n;
                if (wr_en && wr_q == q) begin
                    if (sop) begin
                        if (open_m[q] || eop) err_m[q] = 1;
                        open_m[q] = !eop;
                        len_m[q] = eop ? 0 : 1;
                    end else if (eop) begin
                        if (!open_m[q] || len_m[q] < 3) err_m[q] = 1;
                        open_m[q] = 0; len_m[q] = 0;
                    end else if (open_m[q] && len_m[q] < 3) begin
                        len_m[q] = len_m[q] + 1;
                    end
                end
            end
        end
    endtask

    task automatic check_outs(string tag);
        logic [NQ-1:0] ev, ee;
        logic ef;
        bit   em;
        ev = exp_vec();
        ee = exp_err();
        em = mode_f();
        ef = em ? (cnt_m[rd_sel_q] != 0) : ae_flag_in;
        checks++;
        if (status_vec !== ev || err_vec !== ee || status_flag !== ef || mode_active !== em) begin
            fails++;
            $display("FAIL %s: act vec=%h err=%h flag=%b mode=%b exp vec=%h err=%h flag=%b mode=%b",
                     tag, status_vec, err_vec, status_flag, mode_active, ev, ee, ef, em);
        end
    endtask

    // Inputs are already stable; clock once, update the model, check at negedge.
    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_outs(tag);
    endtask

    task automatic op(bit we, int wq, bit ws, bit wend, bit re, int rq, bit rend,
                      bit fl, int fq, string tag);
        wr_en = we; wr_q = QW'(wq);
        wr_word = {2'b00, wend, ws, $urandom()};
        rd_en = re; rd_q = QW'(rq);
        rd_word = {2'b00, rend, 1'b0, $urandom()};
        flush_en = fl; flush_q = QW'(fq);
        tick(tag);
    endtask

    task automatic idle(string tag);
        op(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic send_pkt(int q, int n, string tag);
        for (int i = 0; i < n; i++) op(1, q, i == 0, i == n - 1, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic read_pkt(int q, int n, string tag);
        for (int i = 0; i < n; i++) op(0, 0, 0, 0, 1, q, i == n - 1, 0, 0, tag);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: act=timeout exp=completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_outs("R1 reset state, tracking active at full width");

        // R3: ready only after the end-marker word; R7 flag on selected queue
        rd_sel_q = 3'd1;
        send_pkt(1, 4, "R3 count up on end marker");
        rd_sel_q = 3'd2;
        idle("R7 flag follows selected queue (empty)");
        rd_sel_q = 3'd1;
        idle("R7 flag follows selected queue (ready)");

        // R4: draining the only packet clears ready
        read_pkt(1, 4, "R4 count down on end-marker read");

        // R5: saturation and floor
        for (int k = 0; k < 9; k++) send_pkt(2, 4, "R5 fill past limit");
        for (int k = 0; k < 7; k++) read_pkt(2, 1, "R5 drain saturated count");
        read_pkt(2, 1, "R5 floor at zero");
        send_pkt(2, 4, "R5 no negative count");
        read_pkt(2, 1, "R5 drain after floor");

        // R6: simultaneous increment and decrement
        send_pkt(3, 4, "R6 setup");
        op(1, 3, 0, 1, 1, 3, 1, 0, 0, "R6 inc and dec cancel");
        op(1, 3, 1, 1, 1, 3, 1, 0, 0, "R6 inc and dec cancel again");

        // R8 short packet; R10 still counted
        send_pkt(4, 3, "R8 short packet flags error, R10 counts it");
        send_pkt(4, 4, "R10 error stays set");

        // R9: start inside open packet; lone end marker
        op(1, 5, 1, 0, 0, 0, 0, 0, 0, "R9 open packet");
        op(1, 5, 1, 0, 0, 0, 0, 0, 0, "R9 start while open");
        op(1, 6, 0, 1, 0, 0, 0, 0, 0, "R9 end with nothing open");

        // R11: flush wins over a same-cycle write and leaves others alone
        op(1, 4, 0, 1, 0, 0, 0, 1, 4, "R11 flush beats write");
        op(1, 5, 1, 0, 0, 0, 0, 1, 5, "R11 flush clears open packet");
        send_pkt(5, 4, "R11 clean packet after flush");

        // R1/R2/R12: narrow width disables tracking
        wr_bus_w = 2'd1;
        ae_flag_in = 1'b0;
        idle("R1 narrow input width disables tracking, R2 passthrough");
        send_pkt(7, 4, "R12 writes ignored when off");
        op(1, 7, 0, 1, 0, 0, 0, 0, 0, "R12 no error when off");
        read_pkt(3, 1, "R12 reads ignored when off");
        wr_bus_w = 2'd0; rd_bus_w = 2'd2;
        idle("R1 narrow output width disables tracking");
        rd_bus_w = 2'd0; mode_req = 1'b0;
        idle("R1 no request disables tracking");
        mode_req = 1'b1;
        idle("R12 state unchanged after off period");

        // Random mix against the reference model
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(99) == 0) mode_req = ~mode_req;
            if ($urandom_range(149) == 0) wr_bus_w = 2'($urandom_range(2));
            if ($urandom_range(149) == 0) rd_bus_w = 2'($urandom_range(2));
            if ($urandom_range(199) == 0) begin wr_bus_w = 2'd0; rd_bus_w = 2'd0; mode_req = 1'b1; end
            rd_sel_q = QW'($urandom_range(NQ - 1));
            ae_vec_in = 8'($urandom());
            ae_flag_in = 1'($urandom());
            op($urandom_range(2) != 0, $urandom_range(NQ - 1),
               $urandom_range(4) == 0, $urandom_range(3) == 0,
               $urandom_range(2) == 0, $urandom_range(NQ - 1),
               $urandom_range(3) == 0,
               $urandom_range(49) == 0, $urandom_range(NQ - 1),
               "R3 R4 R5 R6 R8 R9 R11 random mix");
        end

        done = 1;
        finish_run();
    end
endmodule